// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running 16-bit count at the moment a chosen edge appears on a trigger line. The trigger is either an external capture pin or a comparator result bit. A control bit chooses between the two. The selected line passes through a two-stage synchronizer. An optional filter follows it and accepts a new level only after four successive samples agree on that level. An edge detector comes next, and it can be set for rising or falling edges. When a capture occurs, the count goes into a 16-bit capture register and a sticky flag is raised. The flag can drive an interrupt request.

Software reaches the block through a byte-wide register port. The low byte of the capture register is at address 0, the high byte at address 1, control at address 2 and status at address 3. Each access takes exactly one cycle and is always accepted, so the port has no handshake and no back-pressure. The read data is combinational and follows `bus_addr`. The side effects of an access happen at the clock edge where `bus_rd` or `bus_wr` is high. A single temporary byte lets 16-bit reads and writes appear as one atomic pair. When the surrounding timer uses the capture register as its TOP value, the capture path is muted, but the register can still be written.

Top module: `tcap_unit`

## Requirements
- R1: After reset the capture register, the temporary byte, the control byte and the flag are all zero, and `irq` is low.
- R2: Control bit 0 selects the trigger: 0 takes `trig_pin` and 1 takes `cmp_out`. The input that is not selected never causes a capture.
- R3: Control bit 1 selects the edge: 1 for rising and 0 for falling. With the filter off, suppose a new level is first present before clock edge k. The capture then happens at edge k+2 and stores the `cnt_val` present just before that edge.
- R4: With control bit 2 set, the capture happens four cycles later than in R3, at edge k+6. A level that lasts fewer than four cycles produces no capture.
- R5: Writing the source select can cause a capture if the newly selected line has a different level. That capture is not suppressed.
- R6: While `top_mode` is high no capture occurs. The capture register changes only through a write to address 0.
- R7: Every capture overwrites the capture register, whether or not the earlier value was read.
- R8: A capture sets status bit 0. Writing 1 to status bit 0 clears the flag. If a clear and a capture happen in the same cycle, the flag ends up set.
- R9: `irq` is status bit 0 ANDed with control bit 3.
- R10: A write to address 1 loads the temporary byte. A write to address 0 stores the temporary byte as the high byte and the written data as the low byte, both at once. If a capture happens in the same cycle, the capture wins.
- R11: A read of address 0 returns the low byte and copies the current high byte into the temporary byte. A read of address 1 returns the temporary byte.
- R12: Address 2 reads back the four control bits in bits 3..0, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_pin | input | 1 | External capture trigger line |
| cmp_out | input | 1 | Comparator result used as the alternative trigger |
| cnt_val | input | 16 | Current value of the free-running count |
| top_mode | input | 1 | High while the capture register serves as the count TOP |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (causes the side effect of R11) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Capture interrupt request |

## Verification
A fault in the synchronizer or filter history makes captures appear a few cycles too early or too late. Because the count changes every cycle, the stored count value is wrong at the next low-byte read. A stale edge-detector state produces an extra capture or a missing one, and this shows on `irq` within one cycle when interrupts are enabled. It also shows in the status byte at the next read. Corruption of the temporary byte shows as a mismatched high byte on the read of address 1 that follows a low-byte read, or as a wrong high byte after the committing write.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_CAP_LO = 2'd0,
    REG_CAP_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_sel_e;

  // control byte, bits 3..0
  typedef struct packed {
    logic irq_en;     // bit 3
    logic filt_en;    // bit 2
    logic edge_rise;  // bit 1
    logic src_cmp;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/tcap_sampler.sv
module tcap_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic filt_en,
  output logic lvl
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;
  logic                   filt_lvl;

  // synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate
  assign sync_out = sync_q[SYNC_STAGES-1];

  // agreement filter, clocked every system cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[FILT_LEN-2:0], sync_out};
      filt_q <= filt_lvl;
    end
  end

  always_comb begin
    if (&hist_q)       filt_lvl = 1'b1;
    else if (~|hist_q) filt_lvl = 1'b0;
    else               filt_lvl = filt_q;
  end

  assign lvl = filt_en ? filt_lvl : sync_out;

  // R4
  filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ($past(sync_out, 2) == filt_q && $past(sync_out, 3) == filt_q));
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  input  logic block,
  output logic evt
);
  logic prev_q;
  logic up_edge;
  logic down_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign up_edge   = lvl & ~prev_q;
  assign down_edge = ~lvl & prev_q;
  assign evt       = (rise_sel ? up_edge : down_edge) & ~block;
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [CNT_W-1:0] cnt,
  input  reg_sel_e         addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output ctrl_t            ctrl,
  output logic             irq
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] cap_q;
  logic [HI_W-1:0]  tmp_q;
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic             flag_clr;

  assign flag_clr = wr && addr == REG_STAT && wdata[0];

  // capture register: capture beats software commit
  always_ff @(posedge clk) begin
    if (!rst_n)                            cap_q <= '0;
    else if (evt)                          cap_q <= cnt;
    else if (wr && addr == REG_CAP_LO)     cap_q <= {tmp_q, wdata};
  end

  // temporary high byte shared by reads and writes
  always_ff @(posedge clk) begin
    if (!rst_n)                            tmp_q <= '0;
    else if (wr && addr == REG_CAP_HI)     tmp_q <= wdata[HI_W-1:0];
    else if (!wr && rd && addr == REG_CAP_LO) tmp_q <= cap_q[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            ctrl_q <= '0;
    else if (wr && addr == REG_CTRL)       ctrl_q <= ctrl_t'(wdata[3:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (evt)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      REG_CAP_LO: rdata = cap_q[BYTE_W-1:0];
      REG_CAP_HI: rdata = BYTE_W'(tmp_q);
      REG_CTRL:   rdata = {{(BYTE_W-4){1'b0}}, ctrl_q};
      default:    rdata = {{(BYTE_W-1){1'b0}}, flag_q};
    endcase
  end

  assign ctrl = ctrl_q;
  assign irq  = flag_q & ctrl_q.irq_en;

  // R8
  flag_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  // R7
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap_q == $past(cnt));
  // R10
  pair_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_CAP_LO && !evt) |=> cap_q == {$past(tmp_q), $past(wdata)});
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_pin,
  input  logic        cmp_out,
  input  logic [15:0] cnt_val,
  input  logic        top_mode,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq
);
  localparam int CNT_W = 2 * BYTE_W;

  ctrl_t ctrl;
  logic  trig_raw;
  logic  lvl;
  logic  evt;

  assign trig_raw = ctrl.src_cmp ? cmp_out : trig_pin;

  tcap_sampler #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (trig_raw),
    .filt_en (ctrl.filt_en),
    .lvl     (lvl)
  );

  tcap_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .rise_sel (ctrl.edge_rise),
    .block    (top_mode),
    .evt      (evt)
  );

  tcap_regs #(.CNT_W(CNT_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .cnt   (cnt_val),
    .addr  (reg_sel_e'(bus_addr)),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .ctrl  (ctrl),
    .irq   (irq)
  );

  // R6
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mode && !(bus_wr && bus_addr == REG_CAP_LO)) |=> $stable(u_regs.cap_q));
endmodule

// File: tb/tcap_unit_test.sv
`timescale 1ns/1ps
module tcap_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_pin = 1'b0, cmp_out = 1'b0, top_mode = 1'b0;
  logic [15:0] cnt_val = '0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;

  always #4 clk = ~clk;

  tcap_unit uut (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .cmp_out(cmp_out),
    .cnt_val(cnt_val), .top_mode(top_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  // reference state derived from the requirements
  logic [3:0]  m_ctrl = '0;
  logic [15:0] m_cap = '0;
  logic [7:0]  m_tmp = '0;
  logic        m_flag = 1'b0, m_fq = 1'b0, m_prev = 1'b0;
  logic [6:1]  hr = '0;
  logic [15:0] last_cnt = '0;
  logic [7:0]  last_rd = '0;
  logic cur_pin = 1'b0, cur_cmp = 1'b0, cur_top = 1'b0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_cap[7:0];
      2'd1: return m_tmp;
      2'd2: return {4'b0, m_ctrl};
      default: return {7'b0, m_flag};
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] a);
    case (a)
      2'd0: return "R7";
      2'd1: return "R11";
      2'd2: return "R12";
      default: return "R8";
    endcase
  endfunction

  task automatic step(logic rd, logic wr, logic [1:0] a, logic [7:0] wd);
    logic raw, fl, lv, ev;
    @(negedge clk);
    trig_pin = cur_pin; cmp_out = cur_cmp; top_mode = cur_top;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    cnt_val = 16'($urandom); last_cnt = cnt_val;
    #1;
    check("R9", {15'b0, irq}, {15'b0, m_flag & m_ctrl[3]});
    last_rd = bus_rdata;
    if (rd) check(tag_of(a), {8'b0, bus_rdata}, {8'b0, exp_rd(a)});
    @(posedge clk);
    raw = m_ctrl[0] ? cur_cmp : cur_pin;
    if (&hr[6:3])       fl = 1'b1;
    else if (~|hr[6:3]) fl = 1'b0;
    else                fl = m_fq;
    lv = m_ctrl[2] ? fl : hr[2];
    ev = (m_ctrl[1] ? (lv & ~m_prev) : (~lv & m_prev)) & ~cur_top;
    m_fq = fl; m_prev = lv;
    hr = {hr[5:1], raw};
    if (wr) begin
      case (a)
        2'd0: if (!ev) m_cap = {m_tmp, wd};
        2'd1: m_tmp = wd;
        2'd2: m_ctrl = wd[3:0];
        default: if (wd[0]) m_flag = 1'b0;
      endcase
    end else if (rd && a == 2'd0) m_tmp = m_cap[15:8];
    if (ev) begin m_cap = last_cnt; m_flag = 1'b1; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'h00);
  endtask
  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask
  task automatic rd_reg(logic [1:0] a);
    step(1'b1, 1'b0, a, 8'h00);
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] exp;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values at the ports
    check("R1", {15'b0, irq}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a));
      check("R1", {8'b0, last_rd}, 16'h0);
    end

    // R3 rising edge, unfiltered latency
    wr_reg(2'd2, 8'h0A);
    idle(6);
    cur_pin = 1'b1;
    idle(3);
    exp = last_cnt;
    rd_reg(2'd0); check("R3", {8'b0, last_rd}, {8'b0, exp[7:0]});
    rd_reg(2'd1); check("R11", {8'b0, last_rd}, {8'b0, exp[15:8]});
    rd_reg(2'd3); check("R8", {8'b0, last_rd}, 16'h1);
    check("R9", {15'b0, irq}, 16'h1);
    wr_reg(2'd3, 8'h01);
    rd_reg(2'd3); check("R8", {8'b0, last_rd}, 16'h0);

    // R4 filter: short pulse rejected, long level delayed by four
    wr_reg(2'd2, 8'h06);
    cur_pin = 1'b0; idle(10);
    wr_reg(2'd3, 8'h01);
    cur_pin = 1'b1; idle(3);
    cur_pin = 1'b0; idle(10);
    rd_reg(2'd3); check("R4", {8'b0, last_rd}, 16'h0);
    cur_pin = 1'b1;
    idle(5);
    rd_reg(2'd3); check("R4", {8'b0, last_rd}, 16'h0);
    idle(1);
    exp = last_cnt;
    rd_reg(2'd0); check("R4", {8'b0, last_rd}, {8'b0, exp[7:0]});

    // R6 top mode blocks captures, register still writable
    wr_reg(2'd2, 8'h02);
    wr_reg(2'd3, 8'h01);
    cur_top = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cur_pin = 1'b0; idle(4);
      cur_pin = 1'b1; idle(4);
    end
    rd_reg(2'd3); check("R6", {8'b0, last_rd}, 16'h0);
    wr_reg(2'd1, 8'hAB);
    wr_reg(2'd0, 8'hCD);
    rd_reg(2'd0); check("R10", {8'b0, last_rd}, 16'h00CD);
    rd_reg(2'd1); check("R10", {8'b0, last_rd}, 16'h00AB);
    cur_top = 1'b0; idle(4);

    // R5 source switch produces a capture
    cur_pin = 1'b0; cur_cmp = 1'b1; idle(6);
    wr_reg(2'd3, 8'h01);
    wr_reg(2'd2, 8'h03);
    idle(4);
    rd_reg(2'd3); check("R5", {8'b0, last_rd}, 16'h1);

    // R2 unselected pin ignored
    wr_reg(2'd3, 8'h01);
    for (int i = 0; i < 3; i++) begin
      cur_pin = 1'b1; idle(3);
      cur_pin = 1'b0; idle(3);
    end
    rd_reg(2'd3); check("R2", {8'b0, last_rd}, 16'h0);

    // R10 capture beats same-cycle commit
    wr_reg(2'd2, 8'h02);
    idle(6);
    wr_reg(2'd3, 8'h01);
    cur_pin = 1'b1; idle(2);
    wr_reg(2'd0, 8'h55);
    exp = last_cnt;
    rd_reg(2'd0); check("R10", {8'b0, last_rd}, {8'b0, exp[7:0]});

    // R7 overwrite without reading
    cur_pin = 1'b0; idle(4);
    cur_pin = 1'b1; idle(3);
    cur_pin = 1'b0; idle(4);
    cur_pin = 1'b1; idle(3);
    exp = last_cnt;
    rd_reg(2'd0); check("R7", {8'b0, last_rd}, {8'b0, exp[7:0]});
    rd_reg(2'd1); check("R7", {8'b0, last_rd}, {8'b0, exp[15:8]});

    // R12 control readback
    wr_reg(2'd2, 8'h0B);
    rd_reg(2'd2); check("R12", {8'b0, last_rd}, 16'h000B);

    // random phase checked against the reference state
    for (int i = 0; i < 5000; i++) begin
      int r;
      if ($urandom_range(7) == 0) cur_pin = ~cur_pin;
      if ($urandom_range(7) == 0) cur_cmp = ~cur_cmp;
      if ($urandom_range(63) == 0) cur_top = ~cur_top;
      r = int'($urandom_range(15));
      if (r < 4)       rd_reg(2'($urandom_range(3)));
      else if (r == 4) wr_reg(2'($urandom_range(3)), 8'($urandom));
      else             idle(1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule